// File: doc/BRIEF.md
# I2S Serial Audio Receiver

This block is the receive side of an I2S audio port. It takes the serial bit clock, the word-select line and the serial data line from the pins. All three pass through two flip-flop stages into the system clock domain. On every rising edge of the bit clock the block samples one data bit, most significant bit first. A change of word select marks a word boundary, and the most significant bit of the new word arrives on the next bit-clock rising edge. The same receive logic serves whether a neighbouring generator or an external master drives the bit clock and word select, because both reach this block as inputs.

Each channel sample is cut into 16-bit packets and delivered through a single-entry receive buffer. A 16-bit sample takes one packet. A 24-bit or 32-bit sample in a 32-bit channel takes two packets. A flag shows that the buffer holds an unread packet, and a second flag shows which channel that packet came from. A third flag marks an overrun. Each condition can raise the interrupt line through its own enable. When the enable is cleared in the middle of a word, reception continues to the end of that word before the block stops.

The control state machine has four states. IDLE means disabled. ARM means enabled and waiting for a word-select change. SHIFT means collecting the bits of a word. SKIP means the packets of the word are complete and the remaining bits of the channel slot are discarded. The transitions are:
- IDLE→ARM when the block is enabled.
- ARM→IDLE when the enable is cleared.
- ARM→SHIFT, SHIFT→SHIFT and SKIP→SHIFT on a word-select change while enabled.
- SHIFT→SKIP once the last packet of the word has been delivered.
- SHIFT→IDLE and SKIP→IDLE on a word-select change while disabled.

Top module: `i2s_audio_rx`

## Requirements
- R1: The data line is sampled on each bit-clock rising edge after two synchroniser stages, most significant bit first. The first bit of a word is the one sampled on the rising edge after the edge at which the new word-select level is first seen.
- R2: With 16-bit data (`cfg_dlen` = 00 or 11), each channel word yields exactly one packet holding its 16 bits.
- R3: A delivered packet appears on `rx_data` and sets `rxne`. `irq` is high while `rxne` and `rxne_ie` are both high.
- R4: A one-cycle pulse on `rd_data` clears `rxne`, and `irq` falls when no other interrupt source is active.
- R5: `chside` gives the word-select level of the word that the buffered packet came from: 0 for the left channel, 1 for the right channel.
- R6: If a packet completes while `rxne` is set and no read is in progress, `ovr` sets, the buffer keeps the earlier packet and the new packet is lost. `irq` is high while `ovr` and `err_ie` are both high.
- R7: `ovr` clears only when a `rd_data` pulse is followed later by a `rd_stat` pulse. A `rd_stat` pulse on its own leaves `ovr` set.
- R8: With 24-bit data (`cfg_dlen` = 01) in a 32-bit channel, a word yields two packets. The first holds the upper 16 bits. The second holds the low 8 bits in its upper byte and zeros in its lower byte.
- R9: With 32-bit data (`cfg_dlen` = 10) in a 32-bit channel, a word yields two packets: the upper half, then the lower half.
- R10: With a 16-bit channel (`cfg_ch32` = 0), every word yields a single 16-bit packet whatever `cfg_dlen` holds.
- R11: Clearing `en` in the middle of a word lets that word finish and deliver all its packets. No later word is received.
- R12: After `en` is set, reception starts at the next word-select change. The bits of the word already in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i2s_sck | input | 1 | Serial bit clock from the pin |
| i2s_ws | input | 1 | Word select from the pin (0 left, 1 right) |
| i2s_sd | input | 1 | Serial data from the pin |
| en | input | 1 | Receiver enable |
| cfg_dlen | input | 2 | Data length: 00 16-bit, 01 24-bit, 10 32-bit, 11 16-bit |
| cfg_ch32 | input | 1 | Channel slot length: 1 for 32 bits, 0 for 16 bits |
| rxne_ie | input | 1 | Interrupt enable for buffer not empty |
| err_ie | input | 1 | Interrupt enable for overrun |
| rd_data | input | 1 | One-cycle pulse: host reads the data register |
| rd_stat | input | 1 | One-cycle pulse: host reads the status register |
| rx_data | output | 16 | Receive buffer contents |
| rxne | output | 1 | Receive buffer holds an unread packet |
| ovr | output | 1 | Overrun flag |
| chside | output | 1 | Channel of the buffered packet |
| irq | output | 1 | Combined interrupt request |

## Verification
The embedded properties are evaluated on every cycle. They check that:
- a packet arriving at an empty or just-read buffer is the one that appears on `rx_data` with `rxne` set;
- an overrun freezes the buffer and sets `ovr`, and `ovr` stays set until a status read;
- a data read clears `rxne`;
- no packet leaves the deserialiser while it is in IDLE or ARM;
- the bit-clock edge strobe lasts a single cycle.

Only the directed scenarios can show the following: bit order and the framing against word select, how the data and channel lengths split a word into packets, the zero padding of the 24-bit tail, the channel tag of each packet, the two-step overrun clear, and the boundaries at which enabling and disabling take effect.

// File: rtl/i2srx_pkg.sv
package i2srx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_ARM   = 2'd1,
        RX_SHIFT = 2'd2,
        RX_SKIP  = 2'd3
    } rx_state_e;

    typedef enum logic [1:0] {
        DL_16  = 2'b00,
        DL_24  = 2'b01,
        DL_32  = 2'b10,
        DL_RSV = 2'b11
    } dlen_e;

endpackage

// File: rtl/i2srx_sync.sv
// Multi-stage synchroniser for the pin inputs, with a rising-edge strobe on bit 0.
module i2srx_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         rise0
);

    logic prev0;

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '0;
                end else begin
                    chain <= {chain[STAGES-2:0], din[g]};
                end
            end
            assign dout[g] = chain[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev0 <= 1'b0;
        end else begin
            prev0 <= dout[0];
        end
    end

    assign rise0 = dout[0] & ~prev0;

    // R1: one strobe per bit-clock rising edge, never two cycles in a row
    p_rise_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rise0 |=> !rise0);

endmodule

// File: rtl/i2srx_deser.sv
// Word framing and packet cutting, driven by word select.
module i2srx_deser
    import i2srx_pkg::*;
#(
    parameter int PKT_W = 16,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [1:0]       cfg_dlen,
    input  logic             cfg_ch32,
    input  logic             bit_stb,
    input  logic             sd,
    input  logic             ws,
    output logic             pkt_vld,
    output logic [PKT_W-1:0] pkt_data,
    output logic             pkt_side
);

    localparam int TAIL24 = 24 - PKT_W;
    localparam logic [CNT_W-1:0] CNT_HI   = CNT_W'(PKT_W);
    localparam logic [CNT_W-1:0] CNT_T24  = CNT_W'(24);
    localparam logic [CNT_W-1:0] CNT_T32  = CNT_W'(32);

    rx_state_e          state, state_n;
    logic [PKT_W-1:0]   shreg;
    logic [PKT_W-1:0]   shift_n;
    logic [CNT_W-1:0]   cnt, cnt_n;
    logic [CNT_W-1:0]   tail_at;
    logic               side;
    logic               ws_last;
    logic               ws_edge;
    logic               two_pkt;
    logic               is24;
    logic               emit_hi, emit_lo;
    logic               start;

    // ---- derived configuration and per-bit decode ----
    always_comb begin
        is24    = (cfg_dlen == DL_24);
        two_pkt = cfg_ch32 && ((cfg_dlen == DL_24) || (cfg_dlen == DL_32));
        tail_at = is24 ? CNT_T24 : CNT_T32;
        shift_n = {shreg[PKT_W-2:0], sd};
        cnt_n   = cnt + 1'b1;
        ws_edge = bit_stb && (ws != ws_last);
        emit_hi = (state == RX_SHIFT) && bit_stb && (cnt_n == CNT_HI);
        emit_lo = (state == RX_SHIFT) && bit_stb && two_pkt && (cnt_n == tail_at);
        start   = ws_edge && en && (state != RX_IDLE);
    end

    // ---- next-state logic ----
    always_comb begin
        state_n = state;
        unique case (state)
            RX_IDLE: begin
                if (en) state_n = RX_ARM;
            end
            RX_ARM: begin
                if (!en)          state_n = RX_IDLE;
                else if (ws_edge) state_n = RX_SHIFT;
            end
            RX_SHIFT: begin
                if (ws_edge)                             state_n = en ? RX_SHIFT : RX_IDLE;
                else if (emit_lo || (emit_hi && !two_pkt)) state_n = RX_SKIP;
            end
            RX_SKIP: begin
                if (ws_edge) state_n = en ? RX_SHIFT : RX_IDLE;
            end
        endcase
    end

    // ---- state register ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // ---- datapath and packet outputs ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ws_last  <= 1'b0;
            shreg    <= '0;
            cnt      <= '0;
            side     <= 1'b0;
            pkt_vld  <= 1'b0;
            pkt_data <= '0;
            pkt_side <= 1'b0;
        end else begin
            if (bit_stb) ws_last <= ws;
            if (bit_stb && (state == RX_SHIFT)) begin
                shreg <= shift_n;
                cnt   <= cnt_n;
            end
            if (start) begin
                cnt  <= '0;
                side <= ws;
            end
            pkt_vld <= emit_hi || emit_lo;
            if (emit_hi || emit_lo) begin
                pkt_side <= side;
                if (emit_lo && is24) begin
                    pkt_data <= {shift_n[TAIL24-1:0], {(PKT_W-TAIL24){1'b0}}};
                end else begin
                    pkt_data <= shift_n;
                end
            end
        end
    end

    // R11: nothing leaves the deserialiser while disabled
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_IDLE) |=> !pkt_vld);

    // R12: a partial word seen while arming never produces a packet
    p_arm_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_ARM) |=> !pkt_vld);

endmodule

// File: rtl/i2srx_rxbuf.sv
// Single-entry receive buffer with not-empty, channel and overrun flags.
module i2srx_rxbuf #(
    parameter int PKT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_vld,
    input  logic [PKT_W-1:0] pkt_data,
    input  logic             pkt_side,
    input  logic             rd_data,
    input  logic             rd_stat,
    output logic [PKT_W-1:0] buf_data,
    output logic             rxne,
    output logic             ovr,
    output logic             chside
);

    logic ovr_armed;
    logic ovr_set;
    logic ovr_clr;
    logic load;

    always_comb begin
        load    = pkt_vld && (!rxne || rd_data);
        ovr_set = pkt_vld && rxne && !rd_data;
        ovr_clr = rd_stat && ovr_armed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_data  <= '0;
            rxne      <= 1'b0;
            chside    <= 1'b0;
            ovr       <= 1'b0;
            ovr_armed <= 1'b0;
        end else begin
            if (load) begin
                buf_data <= pkt_data;
                chside   <= pkt_side;
                rxne     <= 1'b1;
            end else if (rd_data) begin
                rxne <= 1'b0;
            end

            if (ovr_set)      ovr <= 1'b1;
            else if (ovr_clr) ovr <= 1'b0;

            if (ovr_clr)              ovr_armed <= 1'b0;
            else if (ovr && rd_data)  ovr_armed <= 1'b1;
        end
    end

    // R3: an accepted packet is what the buffer shows next
    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_vld && (!rxne || rd_data)) |=> (rxne && (buf_data == $past(pkt_data))));

    // R6: overrun keeps the older packet
    p_ovr_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_vld && rxne && !rd_data) |=> (ovr && $stable(buf_data)));

    // R4: data read empties the buffer
    p_read_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !pkt_vld) |=> !rxne);

    // R7: overrun persists until a status read
    p_ovr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !rd_stat) |=> ovr);

endmodule

// File: rtl/i2s_audio_rx.sv
module i2s_audio_rx #(
    parameter int PKT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             i2s_sck,
    input  logic             i2s_ws,
    input  logic             i2s_sd,
    input  logic             en,
    input  logic [1:0]       cfg_dlen,
    input  logic             cfg_ch32,
    input  logic             rxne_ie,
    input  logic             err_ie,
    input  logic             rd_data,
    input  logic             rd_stat,
    output logic [PKT_W-1:0] rx_data,
    output logic             rxne,
    output logic             ovr,
    output logic             chside,
    output logic             irq
);

    localparam int PIN_W = 3;

    logic [PIN_W-1:0] pins_s;
    logic             bit_stb;
    logic             pkt_vld;
    logic [PKT_W-1:0] pkt_data;
    logic             pkt_side;

    i2srx_sync #(
        .W      (PIN_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({i2s_sd, i2s_ws, i2s_sck}),
        .dout  (pins_s),
        .rise0 (bit_stb)
    );

    i2srx_deser #(
        .PKT_W (PKT_W)
    ) u_deser (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .cfg_dlen (cfg_dlen),
        .cfg_ch32 (cfg_ch32),
        .bit_stb  (bit_stb),
        .sd       (pins_s[2]),
        .ws       (pins_s[1]),
        .pkt_vld  (pkt_vld),
        .pkt_data (pkt_data),
        .pkt_side (pkt_side)
    );

    i2srx_rxbuf #(
        .PKT_W (PKT_W)
    ) u_rxbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .pkt_vld  (pkt_vld),
        .pkt_data (pkt_data),
        .pkt_side (pkt_side),
        .rd_data  (rd_data),
        .rd_stat  (rd_stat),
        .buf_data (rx_data),
        .rxne     (rxne),
        .ovr      (ovr),
        .chside   (chside)
    );

    assign irq = (rxne_ie && rxne) || (err_ie && ovr);

endmodule

// File: tb/i2s_audio_rx_tb.sv
module i2s_audio_rx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HB         = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        i2s_sck = 1'b0, i2s_ws = 1'b0, i2s_sd = 1'b0;
    logic        en = 1'b0;
    logic [1:0]  cfg_dlen = 2'b00;
    logic        cfg_ch32 = 1'b1;
    logic        rxne_ie = 1'b0, err_ie = 1'b0;
    logic        rd_auto = 1'b0, rd_man = 1'b0, rd_stat = 1'b0;
    logic        rd_data;
    logic [15:0] rx_data;
    logic        rxne, ovr, chside, irq;

    assign rd_data = rd_auto | rd_man;

    int n_chk = 0;
    int n_err = 0;
    bit auto_rd = 1'b0;

    logic [31:0] w_data [0:7];
    bit          w_side [0:7];
    logic [15:0] cap_data [0:15];
    bit          cap_side [0:15];
    int          cap_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2s_audio_rx dut_i (
        .clk(clk), .rst_n(rst_n), .i2s_sck(i2s_sck), .i2s_ws(i2s_ws), .i2s_sd(i2s_sd),
        .en(en), .cfg_dlen(cfg_dlen), .cfg_ch32(cfg_ch32), .rxne_ie(rxne_ie), .err_ie(err_ie),
        .rd_data(rd_data), .rd_stat(rd_stat), .rx_data(rx_data), .rxne(rxne), .ovr(ovr),
        .chside(chside), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // host model that drains the buffer as soon as it fills
    initial begin
        forever begin
            @(negedge clk);
            if (rd_auto) begin
                rd_auto = 1'b0;
            end else if (auto_rd && rxne) begin
                if (cap_n < 16) begin
                    cap_data[cap_n] = rx_data;
                    cap_side[cap_n] = chside;
                end
                cap_n++;
                rd_auto = 1'b1;
            end
        end
    end

    task automatic apply_reset();
        auto_rd = 1'b0;
        en = 1'b0;
        cap_n = 0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic bit_out(input bit ws_v, input bit sd_v);
        i2s_ws = ws_v;
        i2s_sd = sd_v;
        repeat (HB) @(negedge clk);
        i2s_sck = 1'b1;
        repeat (HB) @(negedge clk);
        i2s_sck = 1'b0;
    endtask

    // word select changes one bit before each word's first bit
    task automatic tx_stream(input int n, input int cl);
        bit nxt;
        bit_out(~w_side[0], 1'b0);
        bit_out(w_side[0], 1'b0);
        for (int i = 0; i < n; i++) begin
            nxt = (i == n - 1) ? ~w_side[i] : w_side[i + 1];
            for (int j = 0; j < cl; j++) begin
                bit_out((j == cl - 1) ? nxt : w_side[i], w_data[i][31 - j]);
            end
        end
        repeat (20) @(negedge clk);
    endtask

    task automatic pulse_rd_data();
        rd_man = 1'b1;
        @(negedge clk);
        rd_man = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_rd_stat();
        rd_stat = 1'b1;
        @(negedge clk);
        rd_stat = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        apply_reset();
        chk(rxne == 1'b0, "R3 reset rxne", {31'd0, rxne}, 32'd0);
        chk(ovr == 1'b0, "R6 reset ovr", {31'd0, ovr}, 32'd0);
        chk(irq == 1'b0, "R3 reset irq", {31'd0, irq}, 32'd0);
        chk(chside == 1'b0, "R5 reset chside", {31'd0, chside}, 32'd0);
    endtask

    // R1 R2 R5: 16-bit words, alternating sides, MSB-first packing
    task automatic t_d16();
        apply_reset();
        cfg_dlen = 2'b00; cfg_ch32 = 1'b0; en = 1'b1; auto_rd = 1'b1;
        w_side[0] = 0; w_data[0] = 32'hA5C3_0000;
        w_side[1] = 1; w_data[1] = 32'h1234_0000;
        w_side[2] = 0; w_data[2] = 32'h8001_0000;
        tx_stream(3, 16);
        chk(cap_n == 3, "R2 packet count 16-bit", cap_n, 3);
        for (int k = 0; k < 3; k++) begin
            chk(cap_data[k] == w_data[k][31:16], "R1 data order", {16'd0, cap_data[k]}, {16'd0, w_data[k][31:16]});
            chk(cap_side[k] == w_side[k], "R5 channel side", {31'd0, cap_side[k]}, {31'd0, w_side[k]});
        end
        chk(ovr == 1'b0, "R6 no overrun when drained", {31'd0, ovr}, 32'd0);
    endtask

    // R8: 24-bit in 32-bit slot
    task automatic t_d24();
        apply_reset();
        cfg_dlen = 2'b01; cfg_ch32 = 1'b1; en = 1'b1; auto_rd = 1'b1;
        w_side[0] = 1; w_data[0] = 32'h1234_56FF;
        w_side[1] = 0; w_data[1] = 32'hABCD_EF77;
        tx_stream(2, 32);
        chk(cap_n == 4, "R8 packet count 24-bit", cap_n, 4);
        chk(cap_data[0] == 16'h1234, "R8 first packet", {16'd0, cap_data[0]}, 32'h1234);
        chk(cap_data[1] == 16'h5600, "R8 tail packet padded", {16'd0, cap_data[1]}, 32'h5600);
        chk(cap_data[2] == 16'hABCD, "R8 first packet word 2", {16'd0, cap_data[2]}, 32'hABCD);
        chk(cap_data[3] == 16'hEF00, "R8 tail packet word 2", {16'd0, cap_data[3]}, 32'hEF00);
        chk(cap_side[1] == 1'b1 && cap_side[3] == 1'b0, "R5 side per packet", {30'd0, cap_side[1], cap_side[3]}, 32'd2);
    endtask

    // R9: 32-bit in 32-bit slot
    task automatic t_d32();
        apply_reset();
        cfg_dlen = 2'b10; cfg_ch32 = 1'b1; en = 1'b1; auto_rd = 1'b1;
        w_side[0] = 0; w_data[0] = 32'hDEAD_BEEF;
        tx_stream(1, 32);
        chk(cap_n == 2, "R9 packet count 32-bit", cap_n, 2);
        chk(cap_data[0] == 16'hDEAD, "R9 upper half", {16'd0, cap_data[0]}, 32'hDEAD);
        chk(cap_data[1] == 16'hBEEF, "R9 lower half", {16'd0, cap_data[1]}, 32'hBEEF);
    endtask

    // R10: 16-bit slot forces single packet
    task automatic t_ch16();
        apply_reset();
        cfg_dlen = 2'b10; cfg_ch32 = 1'b0; en = 1'b1; auto_rd = 1'b1;
        w_side[0] = 0; w_data[0] = 32'h4E21_0000;
        w_side[1] = 1; w_data[1] = 32'h7B0A_0000;
        tx_stream(2, 16);
        chk(cap_n == 2, "R10 one packet per word", cap_n, 2);
        chk(cap_data[1] == 16'h7B0A, "R10 packet content", {16'd0, cap_data[1]}, 32'h7B0A);
    endtask

    // R3 R4: flag, interrupt and read clear
    task automatic t_irq_rxne();
        apply_reset();
        cfg_dlen = 2'b00; cfg_ch32 = 1'b1; en = 1'b1; rxne_ie = 1'b1; err_ie = 1'b0;
        w_side[0] = 1; w_data[0] = 32'h5A5A_1234;
        tx_stream(1, 32);
        chk(rxne == 1'b1, "R3 rxne set", {31'd0, rxne}, 32'd1);
        chk(irq == 1'b1, "R3 irq on rxne", {31'd0, irq}, 32'd1);
        chk(rx_data == 16'h5A5A, "R3 buffer data", {16'd0, rx_data}, 32'h5A5A);
        chk(chside == 1'b1, "R5 right side", {31'd0, chside}, 32'd1);
        pulse_rd_data();
        chk(rxne == 1'b0, "R4 rxne cleared by read", {31'd0, rxne}, 32'd0);
        chk(irq == 1'b0, "R4 irq drops", {31'd0, irq}, 32'd0);
        rxne_ie = 1'b0;
    endtask

    // R6 R7: overrun and two-step clear
    task automatic t_ovr();
        apply_reset();
        cfg_dlen = 2'b00; cfg_ch32 = 1'b0; en = 1'b1; rxne_ie = 1'b0; err_ie = 1'b1;
        w_side[0] = 0; w_data[0] = 32'h1111_0000;
        w_side[1] = 1; w_data[1] = 32'h2222_0000;
        tx_stream(2, 16);
        chk(ovr == 1'b1, "R6 overrun set", {31'd0, ovr}, 32'd1);
        chk(irq == 1'b1, "R6 irq on overrun", {31'd0, irq}, 32'd1);
        chk(rx_data == 16'h1111, "R6 earlier packet kept", {16'd0, rx_data}, 32'h1111);
        chk(chside == 1'b0, "R6 earlier side kept", {31'd0, chside}, 32'd0);
        pulse_rd_stat();
        chk(ovr == 1'b1, "R7 status read alone", {31'd0, ovr}, 32'd1);
        pulse_rd_data();
        chk(ovr == 1'b1, "R7 data read alone", {31'd0, ovr}, 32'd1);
        chk(rxne == 1'b0, "R4 rxne after read", {31'd0, rxne}, 32'd0);
        pulse_rd_stat();
        chk(ovr == 1'b0, "R7 cleared by data then status", {31'd0, ovr}, 32'd0);
        chk(irq == 1'b0, "R6 irq drops", {31'd0, irq}, 32'd0);
        err_ie = 1'b0;
    endtask

    // R11: disable in mid-word completes that word only
    task automatic t_disable();
        apply_reset();
        cfg_dlen = 2'b10; cfg_ch32 = 1'b1; en = 1'b1; auto_rd = 1'b1;
        w_side[0] = 0; w_data[0] = 32'hC0DE_F00D;
        w_side[1] = 1; w_data[1] = 32'h3333_4444;
        fork
            tx_stream(2, 32);
            begin
                repeat (12 * 2 * HB) @(negedge clk);
                en = 1'b0;
            end
        join
        chk(cap_n == 2, "R11 only current word", cap_n, 2);
        chk(cap_data[0] == 16'hC0DE && cap_data[1] == 16'hF00D, "R11 word completed",
            {cap_data[0], cap_data[1]}, 32'hC0DE_F00D);
    endtask

    // R12: enabling mid-word waits for the next boundary
    task automatic t_late_en();
        apply_reset();
        cfg_dlen = 2'b00; cfg_ch32 = 1'b0; auto_rd = 1'b1;
        w_side[0] = 0; w_data[0] = 32'h9999_0000;
        w_side[1] = 1; w_data[1] = 32'h6A6A_0000;
        fork
            tx_stream(2, 16);
            begin
                repeat (6 * 2 * HB) @(negedge clk);
                en = 1'b1;
            end
        join
        chk(cap_n == 1, "R12 partial word ignored", cap_n, 1);
        chk(cap_data[0] == 16'h6A6A, "R12 next word received", {16'd0, cap_data[0]}, 32'h6A6A);
        chk(cap_side[0] == 1'b1, "R12 side of next word", {31'd0, cap_side[0]}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset();
        t_d16();
        t_d24();
        t_d32();
        t_ch16();
        t_irq_rxne();
        t_ovr();
        t_disable();
        t_late_en();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule